// File: doc/BRIEF.md
# Bit-Serial Adder with Registered (Moore) Sum Bit

This block adds two W-bit unsigned operands one bit per clock cycle. While the reset input is high, both operands are captured into shift registers. After reset is released, these registers shift right and present their least-significant bits first. A four-state machine holds the running carry and the most recently computed sum bit. The sum bit is a function of the state only, so each result bit reaches the collector one cycle after the operand bits that produce it.

A collector register shifts each sum bit into its top position. A down-counter allows exactly W+1 shifts and then freezes the collector. The first of these shifts only drains the reset-state output. When the counter reaches zero, `done` rises and `sum` holds the result modulo 2^W. The carry out of the top bit is discarded.

The machine has four states, named by carry and sum bit:
- `ST_C0_S0`: carry 0, sum 0.
- `ST_C0_S1`: carry 0, sum 1.
- `ST_C1_S0`: carry 1, sum 0.
- `ST_C1_S1`: carry 1, sum 1.

The transitions depend on the operand bit pair (a,b):
- From a carry-0 state: 00 goes to `ST_C0_S0`, 01 or 10 goes to `ST_C0_S1`, and 11 goes to `ST_C1_S0`.
- From a carry-1 state: 00 goes to `ST_C0_S1`, 01 or 10 goes to `ST_C1_S0`, and 11 goes to `ST_C1_S1`.

Reset forces `ST_C0_S0`.

Top module: `bitser_moore_add`

## Requirements
- R1: One cycle after a clock edge with `rst` high, both `sum` and `done` are 0.
- R2: The state code is {carry, sum bit}, and the serial output is the low state bit. The first collector shift after reset therefore captures 0, and that 0 lands in bit W-1.
- R3: On the second clock edge after reset is released, `sum[W-1]` takes bit 0 of (A+B), one cycle after the operand bits it came from.
- R4: `done` is 0 after W edges following reset release and 1 after W+1 edges.
- R5: When `done` is 1, `sum` equals (A+B) mod 2^W for the operands present at the last reset edge.
- R6: The carry out of bit W-1 is dropped. For example, all-ones plus one gives 0, and 0x80+0x80 gives 0 when W=8.
- R7: Changes on `op_a` or `op_b` while `rst` is low have no effect on the result.
- R8: While `rst` stays low and `done` is 1, `done` stays 1 and `sum` does not change.
- R9: Raising `rst` in the middle of an addition abandons that addition and restarts with the newly presented operands.
- R10: While `done` is 0 and `rst` is low, every edge shifts `sum` right by one position and fills the top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous, active high; captures the operands and restarts |
| op_a | input | W | First operand, sampled while `rst` is high |
| op_b | input | W | Second operand, sampled while `rst` is high |
| sum | output | W | Collected result |
| done | output | 1 | High once all W result bits are collected |

## Verification
The last collector shift and the rise of `done` happen on the same edge, W+1 edges after reset release. The bench samples on both sides of that edge: it expects `done` low together with a partial `sum` after edge W, then `done` high together with the full result after edge W+1.

A reset can also land while a shift is in progress. The bench aborts additions after a few cycles and restarts them with fresh operands. It then confirms that the cleared collector and the new result show no trace of the abandoned addition.

Carry-heavy patterns check that the carry bit held in the state ripples across every position:
- all-ones plus one;
- all-ones plus all-ones;
- top-bit-only pairs.

// File: rtl/sma_pkg.sv
package sma_pkg;

    // State code is {carry, sum_bit}; the serial sum output is bit 0.
    typedef enum logic [1:0] {
        ST_C0_S0 = 2'b00,
        ST_C0_S1 = 2'b01,
        ST_C1_S0 = 2'b10,
        ST_C1_S1 = 2'b11
    } add_st_e;

endpackage

// File: rtl/sma_opshift.sv
module sma_opshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         lsb
);
    logic [W-1:0] q;

    // Parallel load while load is high, otherwise shift toward bit 0 with zero fill.
    always_ff @(posedge clk) begin
        if (load) begin
            q <= din;
        end else begin
            q <= {1'b0, q[W-1:1]};
        end
    end

    assign lsb = q[0];

endmodule

// File: rtl/sma_fsm.sv
module sma_fsm
    import sma_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_a,
    input  logic    bit_b,
    output add_st_e cur_st,
    output logic    s_out
);
    add_st_e nxt_st;
    logic    carry_now;

    assign carry_now = cur_st[1];

    // Next-state selection.
    always_comb begin
        nxt_st = ST_C0_S0;
        unique case ({carry_now, bit_a, bit_b})
            3'b000:          nxt_st = ST_C0_S0;
            3'b001, 3'b010:  nxt_st = ST_C0_S1;
            3'b011:          nxt_st = ST_C1_S0;
            3'b100:          nxt_st = ST_C0_S1;
            3'b101, 3'b110:  nxt_st = ST_C1_S0;
            3'b111:          nxt_st = ST_C1_S1;
            default:         nxt_st = ST_C0_S0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_st <= ST_C0_S0;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // Moore output: depends on the present state only.
    always_comb begin
        s_out = 1'b0;
        unique case (cur_st)
            ST_C0_S0, ST_C1_S0: s_out = 1'b0;
            ST_C0_S1, ST_C1_S1: s_out = 1'b1;
            default:            s_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/sma_collect.sv
module sma_collect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_in,
    output logic [W-1:0] sum,
    output logic         done
);
    // One extra shift drains the reset-state output.
    localparam int SHIFTS = W + 1;
    localparam int CW     = $clog2(SHIFTS + 1);

    logic [CW-1:0] remain;
    logic          run;

    assign run  = (remain != '0);
    assign done = ~run;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= CW'(SHIFTS);
        end else if (run) begin
            remain <= remain - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (run) begin
            sum <= {s_in, sum[W-1:1]};
        end
    end

endmodule

// File: rtl/bitser_moore_add.sv
module bitser_moore_add
    import sma_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         done
);
    logic    a_lsb;
    logic    b_lsb;
    logic    s_bit;
    add_st_e st;

    sma_opshift #(.W(W)) u_shift_a (
        .clk  (clk),
        .load (rst),
        .din  (op_a),
        .lsb  (a_lsb)
    );

    sma_opshift #(.W(W)) u_shift_b (
        .clk  (clk),
        .load (rst),
        .din  (op_b),
        .lsb  (b_lsb)
    );

    sma_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .bit_a  (a_lsb),
        .bit_b  (b_lsb),
        .cur_st (st),
        .s_out  (s_bit)
    );

    sma_collect #(.W(W)) u_collect (
        .clk  (clk),
        .rst  (rst),
        .s_in (s_bit),
        .sum  (sum),
        .done (done)
    );

endmodule

// File: rtl/sma_chk.sv
module sma_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] sum,
    input logic         done
);
    logic seen_edge;

    // Blocks $past from looking before the first clock edge.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!done && sum == '0));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst) done |=> done);

    // R8
    sum_freeze_chk: assert property (@(posedge clk) disable iff (rst) done |=> $stable(sum));

    // R10
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !done) |=> (sum[W-2:0] == $past(sum[W-1:1])));

    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && $rose(done)) |-> !$past(rst));

endmodule

bind bitser_moore_add sma_chk #(.W(W)) u_sma_chk (
    .clk  (clk),
    .rst  (rst),
    .sum  (sum),
    .done (done)
);

// File: tb/test_bitser_moore_add.sv
module test_bitser_moore_add;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] sum;
    logic         done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    bitser_moore_add #(.W(W)) i_bitser_moore_add (
        .clk (clk), .rst (rst), .op_a (op_a), .op_b (op_b), .sum (sum), .done (done)
    );

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] full;
        full = {1'b0, a} + {1'b0, b};
        return full[W-1:0];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // abort_after > 0: reset again after that many edges (R9).
    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit scramble, input int abort_after, input string tag);
        logic [W-1:0] e;
        logic [W-1:0] prev;
        e = ref_sum(a, b);
        @(negedge clk);
        rst = 1'b1; op_a = a; op_b = b;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check({"R1 sum ", tag}, sum, '0);
        check({"R1 done ", tag}, W'(done), '0);
        if (scramble) begin op_a = ~a; op_b = $urandom(); end
        for (int k = 1; k <= W + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (abort_after > 0 && k == abort_after) return;
            if (k == 1) check({"R2 first shift ", tag}, W'(sum[W-1]), '0);
            if (k == 2) check({"R3 bit0 timing ", tag}, W'(sum[W-1]), W'(e[0]));
            if (k == W) check({"R4 done low ", tag}, W'(done), '0);
        end
        check({"R4 done high ", tag}, W'(done), W'(1));
        check({scramble ? "R7 result " : "R5 result ", tag}, sum, e);
        prev = sum;
        op_a = $urandom(); op_b = $urandom();
        for (int k = 0; k < 2; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check({"R8 hold sum ", tag}, sum, prev);
        check({"R8 hold done ", tag}, W'(done), W'(1));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (2) @(posedge clk);
        run_add(8'h00, 8'h00, 0, 0, "zero");
        run_add(8'hFF, 8'h01, 0, 0, "R6 ones+1");
        run_add(8'hFF, 8'hFF, 0, 0, "R6 ones+ones");
        run_add(8'h80, 8'h80, 0, 0, "R6 top");
        run_add(8'h55, 8'hAA, 0, 0, "alt");
        run_add(8'h3C, 8'h0F, 1, 0, "scrambled");
        run_add(8'h12, 8'h34, 0, 3, "abort");
        run_add(8'h0F, 8'h01, 0, 0, "R9 restart");
        run_add(8'h77, 8'h99, 0, W + 1, "abort late");
        run_add(8'h01, 8'h01, 0, 0, "R9 restart2");
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = $urandom();
            rb = $urandom();
            run_add(ra, rb, (i % 4) == 0, 0, "random");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule